// File: doc/BRIEF.md
# Interrupt Descriptor Queue Engine

The engine collects event indications from several internal source units and turns each unmasked one into a 32-bit descriptor word. It holds these words in a small internal FIFO and delivers them to a circular queue in host shared memory. It drives its own single-beat write port as bus master. After every completed memory write it raises an interrupt line, which stays high until the host acknowledges it.

The host sets up and controls the engine through a 32-bit register slave port. Each register sits at a word index on `reg_addr`:
- 0: queue base address.
- 1: queue length, in 32-bit words.
- 2: per-source suppress mask.
- 3: status.
- 4: soft reset.

The engine does nothing until the base has been written and then a non-zero length. Rewriting the base or length later restarts the ring at its first slot and throws away every descriptor still waiting in the FIFO. A write to index 4 clears the block back to its reset state.

Top module: `irq_queue_engine`

## Requirements
- R1: After reset `irq` and `mst_valid` are low, and the base, length, mask and status registers all read 0.
- R2: No source is acknowledged and no master write is issued until the base register is written and then a non-zero length. A length written before the base does not start the engine. Once the engine is started, the FIFO is empty.
- R3: When mask bit i (register 2, bit i) is 1, an event on source i is acknowledged and discarded without producing a descriptor. Other sources are unaffected.
- R4: Each descriptor holds the source number in bits [31:28], zeros in [27:16] and the source's 16-bit event code in [15:0].
- R5: Requesting sources are granted one per cycle in round-robin order. After a grant to source k, the search starts at source k+1 (modulo the source count). After reset the search starts at source 0.
- R6: Write n goes to base + 4·n, where n counts completed master writes since the ring was last restarted. n returns to 0 after reaching length−1.
- R7: The FIFO holds 16 descriptors. An event that wins arbitration while the FIFO is full is acknowledged and dropped, and it sets status bit 1. That bit stays set until 1 is written to it.
- R8: `irq` rises after every completed master write (`mst_valid` and `mst_ready` high at a clock edge). It stays high until 1 is written to status bit 0. A completed write in the same cycle as that clear leaves `irq` high.
- R9: Writing the base or length register while running empties the FIFO, so `mst_valid` falls, and the next descriptor is written to the base address.
- R10: Any write, whatever its data, to register 4 returns every register, the FIFO, the ring index, the arbiter and `irq` to their reset values. The engine then waits for setup again.
- R11: A register access with any byte enable low has no effect when it is a write, and returns 0 when it is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | NSRC | Event request per source, held until acknowledged |
| src_code | input | NSRC×16 | Event code per source, source i in bits [16i+15:16i] |
| src_ack | output | NSRC | Event taken (queued, masked or dropped) at this edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_be | input | 4 | Byte enables; all four needed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mst_valid | output | 1 | Master write request |
| mst_addr | output | ADDR_W | Master write address |
| mst_data | output | 32 | Descriptor word |
| mst_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Interrupt to host |

## Verification
Two pairs of actions can land on the same clock edge: the host clearing a status bit and the engine setting that same bit. For the interrupt bit, the bench holds a descriptor at the FIFO head with `mst_ready` low. It then raises `mst_ready` on the same cycle as a write of 1 to status bit 0, and expects `irq` to still read high afterwards. The scoreboard checks the address and data of the write that completes in that cycle. A second clear must then bring `irq` low.

// File: rtl/iq_pkg.sv
package iq_pkg;
   localparam int CODE_W = 16;
   localparam int DESC_W = 32;

   localparam logic [2:0] RIX_BASE = 3'd0;
   localparam logic [2:0] RIX_LEN  = 3'd1;
   localparam logic [2:0] RIX_MASK = 3'd2;
   localparam logic [2:0] RIX_STAT = 3'd3;
   localparam logic [2:0] RIX_SRST = 3'd4;

   typedef enum logic [1:0] {
      CFG_WAIT_BASE,
      CFG_WAIT_LEN,
      CFG_RUN
   } cfg_e;

   function automatic logic [DESC_W-1:0] pack_desc(input logic [3:0] id,
                                                   input logic [CODE_W-1:0] code);
      return {id, 12'h000, code};
   endfunction
endpackage

// File: rtl/iq_rr_arb.sv
module iq_rr_arb #(
   parameter int N = 4,
   localparam int IDW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [N-1:0]   req,
   output logic [N-1:0]   grant,
   output logic [IDW-1:0] gnt_id
);
   logic [IDW-1:0] last_q;

   always_comb begin
      logic found;
      found  = 1'b0;
      grant  = '0;
      gnt_id = '0;
      for (int off = 1; off <= N; off++) begin
         int cand;
         cand = (int'(last_q) + off) % N;
         if (!found && req[cand]) begin
            found       = 1'b1;
            grant[cand] = 1'b1;
            gnt_id      = IDW'(cand);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= IDW'(N-1);
      else if (clr)     last_q <= IDW'(N-1);
      else if (|req)    last_q <= gnt_id;
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R5
   AST_GNT_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ((grant & req) != '0)); // R5
endmodule

// File: rtl/iq_fifo.sv
module iq_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam bit POW2  = (DEPTH == (1 << PTR_W))
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic [PTR_W:0]   cnt;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign full  = (cnt == (PTR_W+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R7
   AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R6
   AST_FIFO_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty); // R9
endmodule

// File: rtl/iq_ring.sv
module iq_ring #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   input  logic              run,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] addr
);
   logic [LEN_W-1:0] idx, idx_inc;

   assign idx_inc = idx + 1'b1;
   assign addr    = base + ADDR_W'({idx, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (restart) idx <= '0;
      else if (adv)     idx <= (idx_inc == len) ? '0 : idx_inc;
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (idx < len)); // R6
endmodule

// File: rtl/irq_queue_engine.sv
module irq_queue_engine
   import iq_pkg::*;
#(
   parameter int NSRC       = 4,
   parameter int FIFO_DEPTH = 16,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   localparam int IDW       = $clog2(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        src_valid,
   input  logic [NSRC*CODE_W-1:0] src_code,
   output logic [NSRC-1:0]        src_ack,
   input  logic                   reg_wr,
   input  logic [2:0]             reg_addr,
   input  logic [3:0]             reg_be,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   output logic                   mst_valid,
   output logic [ADDR_W-1:0]      mst_addr,
   output logic [DESC_W-1:0]      mst_data,
   input  logic                   mst_ready,
   output logic                   irq
);
   generate
      if (NSRC < 2 || NSRC > 16) begin : g_bad_nsrc
         $error("NSRC must lie in 2..16 to fit the 4-bit source field");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (ADDR_W < LEN_W + 2 || ADDR_W > 32 || LEN_W > 30) begin : g_bad_addr
         $error("ADDR_W must cover the ring span and fit a register");
      end
   endgenerate

   cfg_e              cfg_q;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic [NSRC-1:0]   mask_q;
   logic              ovf_q, irq_q;

   logic wr_ok, base_wr, len_wr, mask_wr, stat_wr, soft_rst;
   logic running, flush, push, pop, ovf_set;
   logic fifo_full, fifo_empty;
   logic [NSRC-1:0] req, grant;
   logic [IDW-1:0]  gnt_id;
   logic [DESC_W-1:0] desc;

   assign wr_ok    = reg_wr && (&reg_be);
   assign base_wr  = wr_ok && (reg_addr == RIX_BASE);
   assign len_wr   = wr_ok && (reg_addr == RIX_LEN);
   assign mask_wr  = wr_ok && (reg_addr == RIX_MASK);
   assign stat_wr  = wr_ok && (reg_addr == RIX_STAT);
   assign soft_rst = wr_ok && (reg_addr == RIX_SRST);

   assign running = (cfg_q == CFG_RUN);
   assign flush   = soft_rst || base_wr || len_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_WAIT_BASE;
      end else if (soft_rst) begin
         cfg_q <= CFG_WAIT_BASE;
      end else if (base_wr) begin
         if (cfg_q == CFG_WAIT_BASE) cfg_q <= CFG_WAIT_LEN;
      end else if (len_wr && cfg_q != CFG_WAIT_BASE) begin
         cfg_q <= (reg_wdata[LEN_W-1:0] != '0) ? CFG_RUN : CFG_WAIT_LEN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0; len_q <= '0; mask_q <= '0;
      end else if (soft_rst) begin
         base_q <= '0; len_q <= '0; mask_q <= '0;
      end else begin
         if (base_wr) base_q <= reg_wdata[ADDR_W-1:0];
         if (len_wr)  len_q  <= reg_wdata[LEN_W-1:0];
         if (mask_wr) mask_q <= reg_wdata[NSRC-1:0];
      end
   end

   // source side: masked requests are swallowed, others arbitrate
   assign req     = running ? (src_valid & ~mask_q) : '0;
   assign src_ack = running ? ((src_valid & mask_q) | grant) : '0;
   assign push    = (|grant) && !fifo_full && !flush;
   assign ovf_set = (|grant) && fifo_full && !flush;
   assign desc    = pack_desc(4'(gnt_id), src_code[CODE_W*int'(gnt_id) +: CODE_W]);

   iq_rr_arb #(.N(NSRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .req(req), .grant(grant), .gnt_id(gnt_id)
   );

   iq_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .push(push), .din(desc), .pop(pop), .dout(mst_data),
      .full(fifo_full), .empty(fifo_empty)
   );

   assign mst_valid = running && !fifo_empty;
   assign pop       = mst_valid && mst_ready;

   iq_ring #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .restart(flush), .adv(pop),
      .run(running), .len(len_q), .base(base_q), .addr(mst_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0; ovf_q <= 1'b0;
      end else if (soft_rst) begin
         irq_q <= 1'b0; ovf_q <= 1'b0;
      end else begin
         if (pop)                        irq_q <= 1'b1;
         else if (stat_wr && reg_wdata[0]) irq_q <= 1'b0;
         if (ovf_set)                    ovf_q <= 1'b1;
         else if (stat_wr && reg_wdata[1]) ovf_q <= 1'b0;
      end
   end
   assign irq = irq_q;

   always_comb begin
      reg_rdata = '0;
      if (&reg_be) begin
         case (reg_addr)
            RIX_BASE: reg_rdata = 32'(base_q);
            RIX_LEN:  reg_rdata = 32'(len_q);
            RIX_MASK: reg_rdata = 32'(mask_q);
            RIX_STAT: reg_rdata = {30'd0, ovf_q, irq_q};
            default:  reg_rdata = '0;
         endcase
      end
   end

   AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !soft_rst) |=> irq); // R8
   AST_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> fifo_empty); // R2
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !soft_rst && !(stat_wr && reg_wdata[1])) |=> ovf_q); // R7
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!irq && !mst_valid && src_ack == '0)); // R10
endmodule

// File: tb/irq_queue_engine_bench.sv
module irq_queue_engine_bench;
   localparam int NSRC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NSRC-1:0]    sv = '0;
   logic [NSRC*16-1:0] sc = '0;
   logic [NSRC-1:0]    sa;
   logic        reg_wr = 1'b0;
   logic [2:0]  ra = '0;
   logic [3:0]  rbe = '0;
   logic [31:0] rwd = '0;
   logic [31:0] rrd;
   logic        mv, mrdy = 1'b1, irq;
   logic [31:0] maddr, mdata;

   irq_queue_engine u_irq_queue_engine (
      .clk(clk), .rst_n(rst_n), .src_valid(sv), .src_code(sc), .src_ack(sa),
      .reg_wr(reg_wr), .reg_addr(ra), .reg_be(rbe), .reg_wdata(rwd), .reg_rdata(rrd),
      .mst_valid(mv), .mst_addr(maddr), .mst_data(mdata), .mst_ready(mrdy), .irq(irq)
   );

   typedef struct { logic [31:0] a; logic [31:0] d; } item_t;
   item_t exp_q[$];
   int checks = 0, errors = 0;
   logic [31:0] m_base = '0;
   int m_len = 0, m_idx = 0, rr_last = NSRC - 1;
   logic [31:0] rv;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic expect_desc(int s, logic [15:0] c);
      item_t it;
      it.a = m_base + 32'(4 * m_idx);
      it.d = {4'(s), 12'h000, c};
      exp_q.push_back(it);
      m_idx = (m_idx + 1 == m_len) ? 0 : m_idx + 1;
   endtask

   task automatic reg_write(logic [2:0] a, logic [31:0] d, logic [3:0] be);
      @(negedge clk);
      reg_wr = 1'b1; ra = a; rwd = d; rbe = be;
      @(negedge clk);
      reg_wr = 1'b0; rbe = '0;
   endtask

   task automatic reg_read(logic [2:0] a, logic [3:0] be, output logic [31:0] d);
      @(negedge clk);
      ra = a; rbe = be;
      #1 d = rrd;
      rbe = '0;
   endtask

   task automatic wait_ack(int s);
      forever begin
         #1;
         if (sa[s]) break;
         @(negedge clk);
      end
   endtask

   // want: a descriptor is expected; arbd: the source takes part in arbitration
   task automatic post(int s, logic [15:0] c, bit want, bit arbd);
      @(negedge clk);
      sv[s] = 1'b1; sc[s*16 +: 16] = c;
      wait_ack(s);
      if (want) expect_desc(s, c);
      if (arbd) rr_last = s;
      @(negedge clk);
      sv[s] = 1'b0;
   endtask

   task automatic post_all(logic [11:0] tag);
      logic [NSRC-1:0] pend;
      pend = '1;
      @(negedge clk);
      for (int s = 0; s < NSRC; s++) sc[s*16 +: 16] = {tag, 4'(s)};
      sv = '1;
      for (int k = 0; k < NSRC; k++) begin
         int want_s, got;
         want_s = -1;
         for (int off = 1; off <= NSRC; off++) begin
            int cand;
            cand = (rr_last + off) % NSRC;
            if (want_s < 0 && pend[cand]) want_s = cand;
         end
         #1;
         got = -1;
         for (int s = 0; s < NSRC; s++) if (sa[s] && got < 0) got = s;
         chk("R5 grant order", 32'(got), 32'(want_s));
         if (want_s >= 0) begin
            expect_desc(want_s, {tag, 4'(want_s)});
            rr_last = want_s;
            pend[want_s] = 1'b0;
         end
         @(negedge clk);
         if (want_s >= 0) sv[want_s] = 1'b0;
      end
      sv = '0;
   endtask

   // monitor: pops the scoreboard on every completed master write
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && mv && mrdy) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R3 unexpected write addr %h data %h expected none", maddr, mdata);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               chk("R6 address", maddr, it.a);
               chk("R4 descriptor", mdata, it.d);
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      checks++; errors++;
      $display("FAIL all requirements: watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 mst_valid", 32'(mv), 0);
      reg_read(3'd0, 4'hF, rv); chk("R1 base", rv, 0);
      reg_read(3'd1, 4'hF, rv); chk("R1 length", rv, 0);
      reg_read(3'd2, 4'hF, rv); chk("R1 mask", rv, 0);
      reg_read(3'd3, 4'hF, rv); chk("R1 status", rv, 0);

      // R2 setup order: length first does not start
      reg_write(3'd1, 32'd8, 4'hF);
      @(negedge clk);
      sv[1] = 1'b1; sc[16 +: 16] = 16'h0011;
      repeat (4) @(negedge clk);
      #1 chk("R2 no ack before base", 32'(sa), 0);
      chk("R2 no write before base", 32'(mv), 0);
      reg_write(3'd0, 32'h0000_1000, 4'hF);
      #1 chk("R2 no ack before length", 32'(sa), 0);
      reg_write(3'd1, 32'd4, 4'hF);
      m_base = 32'h0000_1000; m_len = 4; m_idx = 0;
      wait_ack(1);
      expect_desc(1, 16'h0011); rr_last = 1;
      @(negedge clk); sv[1] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 irq after write", 32'(irq), 1);
      chk("R6 drained", 32'(exp_q.size()), 0);
      reg_write(3'd3, 32'd1, 4'hF);
      #1 chk("R8 irq cleared", 32'(irq), 0);

      // R5 round robin with ring wrap (R6)
      post_all(12'hA50);
      repeat (10) @(negedge clk);
      chk("R6 wrap drained", 32'(exp_q.size()), 0);

      // R3 masked source
      reg_write(3'd2, 32'h4, 4'hF);
      post(2, 16'h0333, 1'b0, 1'b0);
      repeat (6) @(negedge clk);
      chk("R3 masked no write", 32'(mv), 0);
      post(0, 16'h0030, 1'b1, 1'b1);
      repeat (6) @(negedge clk);
      chk("R3 unmasked passes", 32'(exp_q.size()), 0);
      reg_write(3'd2, 32'h0, 4'hF);
      reg_write(3'd3, 32'd1, 4'hF);

      // R7 overflow: 17 events into a 16-deep FIFO with the memory stalled
      mrdy = 1'b0;
      for (int k = 0; k < 17; k++) post(3, 16'h0700 + 16'(k), k < 16, 1'b1);
      reg_read(3'd3, 4'hF, rv); chk("R7 overflow set", rv, 32'h2);
      reg_write(3'd3, 32'h2, 4'hF);
      reg_read(3'd3, 4'hF, rv); chk("R7 overflow cleared", rv, 32'h0);
      mrdy = 1'b1;
      repeat (24) @(negedge clk);
      chk("R7 sixteen delivered", 32'(exp_q.size()), 0);

      // R9 reprogramming flushes
      mrdy = 1'b0;
      for (int k = 0; k < 3; k++) post(0, 16'h0900 + 16'(k), 1'b1, 1'b1);
      chk("R9 pending before flush", 32'(mv), 1);
      exp_q.delete();
      m_base = 32'h0000_2000; m_idx = 0;
      reg_write(3'd0, 32'h0000_2000, 4'hF);
      #1 chk("R9 flushed", 32'(mv), 0);
      mrdy = 1'b1;
      post(1, 16'h0901, 1'b1, 1'b1);
      repeat (5) @(negedge clk);
      chk("R9 restart at base", 32'(exp_q.size()), 0);

      // R8 completion and clear in the same cycle
      mrdy = 1'b0;
      post(2, 16'h0802, 1'b1, 1'b1);
      mrdy = 1'b1;
      reg_wr = 1'b1; ra = 3'd3; rwd = 32'd1; rbe = 4'hF;
      @(negedge clk);
      reg_wr = 1'b0; rbe = '0;
      #1 chk("R8 set wins over clear", 32'(irq), 1);
      reg_write(3'd3, 32'd1, 4'hF);
      #1 chk("R8 later clear", 32'(irq), 0);

      // R11 partial byte enables
      reg_write(3'd0, 32'hABCD_0000, 4'b0111);
      reg_read(3'd0, 4'hF, rv); chk("R11 partial write ignored", rv, 32'h0000_2000);
      reg_read(3'd0, 4'b1110, rv); chk("R11 partial read zero", rv, 0);

      // R10 soft reset
      post(0, 16'h0A00, 1'b1, 1'b1);
      repeat (4) @(negedge clk);
      mrdy = 1'b0;
      post(3, 16'h0A0A, 1'b0, 1'b1);
      reg_write(3'd2, 32'h5, 4'hF);
      reg_write(3'd4, 32'hDEAD_BEEF, 4'hF);
      exp_q.delete(); rr_last = NSRC - 1; m_idx = 0;
      mrdy = 1'b1;
      #1 chk("R10 irq low", 32'(irq), 0);
      chk("R10 no write", 32'(mv), 0);
      reg_read(3'd0, 4'hF, rv); chk("R10 base", rv, 0);
      reg_read(3'd2, 4'hF, rv); chk("R10 mask", rv, 0);
      reg_read(3'd3, 4'hF, rv); chk("R10 status", rv, 0);
      @(negedge clk);
      sv[0] = 1'b1;
      repeat (4) @(negedge clk);
      #1 chk("R10 idle again", 32'(sa), 0);
      sv[0] = 1'b0;

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule